// File: doc/BRIEF.md
# Lockable clock-configuration register bank

This block holds the software-visible configuration of a clock generator as a few byte-wide registers. A serial-bus front end, which is not part of this block, turns bus traffic into a start strobe carrying a starting index, a series of byte-write strobes and an end strobe. The byte index advances by one after each accepted byte. A separate combinational port reads any register at any time.

The frequency register holds a 5-bit frequency select, a spread control bit, a software write-enable bit and a one-shot lock bit. The frequency select and spread bits load from strap pins on the first clock after reset and drive the block's outputs. The clock-enable register gates eight clock outputs. Writes are protected in two ways. The write-enable bit is copied when each transaction starts, so a change to it applies only from the next transaction. The lock bit, once set, freezes every register until the next reset. A status register returns the live strap pin levels.

Top module: `clkcfg_regbank`

## Requirements
- R1: On the first clock after reset is released, register 0 reads {lock=0, spread=spread_i, fs_strap_i, we=0}, that is bit 7 lock, bit 6 spread, bits 5:1 FS[4:0] and bit 0 write-enable. Register 1 reads 8'hFF, fs_o equals fs_strap_i and clk_en_o is 8'hFF.
- R2: In a transaction that starts while bit 0 of register 0 is 0, a byte written to index 0 changes only bit 0. A byte written to index 1 is ignored.
- R3: Setting bit 0 in a protected transaction leaves the later bytes of that same transaction protected. The next transaction accepts full writes.
- R4: Clearing bit 0 in an enabled transaction leaves the later bytes of that transaction accepted. The next transaction is protected, and FS keeps its last written value and does not reload from the straps.
- R5: An accepted byte with bit 7 set at index 0 locks the bank at once. Every later write, including writes to bit 0, is ignored until reset, and reset clears the lock.
- R6: fs_o always equals register 0 bits 5:1 and spread_o equals bit 6. Both change only on the clock after an accepted write to index 0.
- R7: A read of index 0 returns the stored register contents and does not follow the pins. A read of index 4 returns {2'b00, spread_i, fs_strap_i} live.
- R8: clk_en_o equals register 1. A 0 in bit n turns off clock output n.
- R9: Writes to indices other than 0 and 1 are ignored. Reads from indices other than 0, 1 and 4 return 0.
- R10: The first byte of a transaction goes to the start index and each later byte goes to the next index, wrapping modulo 2^IDX_W. A write strobe outside a transaction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| blk_start_i | input | 1 | Start of block transaction |
| blk_idx_i | input | IDX_W | Start index, sampled with blk_start_i |
| wr_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte write data |
| blk_end_i | input | 1 | End of block transaction |
| rd_idx_i | input | IDX_W | Read index |
| rd_data_o | output | 8 | Read data (combinational) |
| fs_strap_i | input | 5 | Frequency-select strap pins |
| spread_i | input | 1 | Spread strap pin |
| fs_o | output | 5 | Frequency select |
| spread_o | output | 1 | Spread control |
| clk_en_o | output | 8 | Clock output enables |

## Verification
The assertions assume that the front end never raises a write strobe in the same cycle as a start strobe. They also assume that no byte arrives in the single strap-loading cycle after reset. The bench keeps to both: each transaction drives its start, its bytes and its end on separate cycles, and every transaction waits until at least two clocks after reset. Stray write strobes are driven only when no transaction is open.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int DW         = 8;
  localparam int FS_W       = 5;
  localparam int REG_FREQ   = 0;
  localparam int REG_CLKEN  = 1;
  localparam int REG_PINS   = 4;
  localparam int WE_BIT     = 0;
  localparam int SPREAD_BIT = 6;
  localparam int LOCK_BIT   = 7;
endpackage

// File: rtl/clkcfg_txn.sv
module clkcfg_txn #(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blk_start_i,
  input  logic [IDX_W-1:0] blk_idx_i,
  input  logic             wr_i,
  input  logic             blk_end_i,
  input  logic             we_bit_i,
  output logic             wr_acc_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             txn_we_o
);
  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic             we_q;

  assign wr_acc_o = wr_i & active_q & ~blk_start_i;
  assign idx_o    = idx_q;
  assign txn_we_o = we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      we_q     <= 1'b0;
    end else if (blk_start_i) begin
      active_q <= 1'b1;
      idx_q    <= blk_idx_i;
      we_q     <= we_bit_i;  // snapshot: new value applies from next block
    end else begin
      if (blk_end_i) active_q <= 1'b0;
      if (wr_acc_o)  idx_q    <= idx_q + 1'b1;
    end
  end

  assert_idx_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc_o && !blk_start_i) |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

  assert_we_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !blk_start_i) |=> $stable(we_q));
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_acc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             txn_we_i,
  input  logic [FS_W-1:0]  fs_strap_i,
  input  logic             spread_i,
  output logic [DW-1:0]    reg0_o,
  output logic [DW-1:0]    reg1_o
);
  logic [DW-1:0] reg0_q, reg1_q;
  logic          loaded_q;
  logic          lock;
  logic          hit0, hit1;

  assign lock = reg0_q[LOCK_BIT];
  assign hit0 = wr_acc_i && !lock && (idx_i == IDX_W'(REG_FREQ));
  assign hit1 = wr_acc_i && !lock && (idx_i == IDX_W'(REG_CLKEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg0_q   <= '0;
      reg1_q   <= '1;
      loaded_q <= 1'b0;
    end else if (!loaded_q) begin
      reg0_q   <= {1'b0, spread_i, fs_strap_i, 1'b0};
      loaded_q <= 1'b1;
    end else begin
      if (hit0) begin
        if (txn_we_i) reg0_q <= wr_data_i;
        else          reg0_q[WE_BIT] <= wr_data_i[WE_BIT];
      end
      if (hit1 && txn_we_i) reg1_q <= wr_data_i;
    end
  end

  assign reg0_o = reg0_q;
  assign reg1_o = reg1_q;

  assert_lock_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && lock) |=> (reg0_q == $past(reg0_q)) && (reg1_q == $past(reg1_q)));

  assert_protected_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && wr_acc_i && !txn_we_i) |=>
      (reg0_q[DW-1:1] == $past(reg0_q[DW-1:1])) && (reg1_q == $past(reg1_q)));

  assert_fs_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && !(wr_acc_i && txn_we_i && idx_i == IDX_W'(REG_FREQ)))
      |=> $stable(reg0_q[SPREAD_BIT:1]));
endmodule

// File: rtl/clkcfg_rdmux.sv
module clkcfg_rdmux
  import clkcfg_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [DW-1:0]    reg0_i,
  input  logic [DW-1:0]    reg1_i,
  input  logic [FS_W-1:0]  fs_strap_i,
  input  logic             spread_i,
  output logic [DW-1:0]    rd_data_o
);
  localparam int PAD_W = DW - FS_W - 1;

  always_comb begin
    rd_data_o = '0;
    if (rd_idx_i == IDX_W'(REG_FREQ))  rd_data_o = reg0_i;
    if (rd_idx_i == IDX_W'(REG_CLKEN)) rd_data_o = reg1_i;
    if (rd_idx_i == IDX_W'(REG_PINS))  rd_data_o = {{PAD_W{1'b0}}, spread_i, fs_strap_i};
  end

  always_comb begin
    if (rd_idx_i != IDX_W'(REG_FREQ) && rd_idx_i != IDX_W'(REG_CLKEN) &&
        rd_idx_i != IDX_W'(REG_PINS))
      assert_unimpl_zero_R9: assert (rd_data_o == '0);
  end
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blk_start_i,
  input  logic [IDX_W-1:0] blk_idx_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             blk_end_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic [FS_W-1:0]  fs_strap_i,
  input  logic             spread_i,
  output logic [FS_W-1:0]  fs_o,
  output logic             spread_o,
  output logic [DW-1:0]    clk_en_o
);
  logic             wr_acc, txn_we;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    reg0, reg1;

  clkcfg_txn #(.IDX_W(IDX_W)) u_txn (
    .clk_i, .rst_ni, .blk_start_i, .blk_idx_i, .wr_i, .blk_end_i,
    .we_bit_i (reg0[WE_BIT]),
    .wr_acc_o (wr_acc),
    .idx_o    (idx),
    .txn_we_o (txn_we)
  );

  clkcfg_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_acc_i  (wr_acc),
    .idx_i     (idx),
    .wr_data_i,
    .txn_we_i  (txn_we),
    .fs_strap_i, .spread_i,
    .reg0_o    (reg0),
    .reg1_o    (reg1)
  );

  clkcfg_rdmux #(.IDX_W(IDX_W)) u_rdmux (
    .rd_idx_i, .reg0_i (reg0), .reg1_i (reg1), .fs_strap_i, .spread_i, .rd_data_o
  );

  assign fs_o     = reg0[FS_W:1];
  assign spread_o = reg0[SPREAD_BIT];
  assign clk_en_o = reg1;
endmodule

// File: tb/clkcfg_regbank_bench.sv
module clkcfg_regbank_bench;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       blk_start_i = 0, wr_i = 0, blk_end_i = 0, spread_i = 1'b1;
  logic [2:0] blk_idx_i = 0, rd_idx_i = 0;
  logic [7:0] wr_data_i = 0, rd_data_o, clk_en_o;
  logic [4:0] fs_strap_i = 5'b10110, fs_o;
  logic       spread_o;
  int         n_run = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  clkcfg_regbank u_clkcfg_regbank (.*);

  // {start idx, byte count, d0, d1, expected reg0, expected reg1}
  localparam int NV = 9;
  localparam logic [36:0] VEC [NV] = '{
    {3'd0, 2'd2, 8'hFF, 8'h00, 8'h6D, 8'hFF},
    {3'd1, 2'd1, 8'h0F, 8'h00, 8'h6D, 8'h0F},
    {3'd0, 2'd2, 8'h12, 8'hA5, 8'h12, 8'hA5},
    {3'd1, 2'd1, 8'hFF, 8'h00, 8'h12, 8'hA5},
    {3'd0, 2'd1, 8'hE1, 8'h00, 8'h13, 8'hA5},
    {3'd2, 2'd2, 8'h55, 8'h55, 8'h13, 8'hA5},
    {3'd7, 2'd2, 8'h00, 8'h3D, 8'h3D, 8'hA5},
    {3'd0, 2'd2, 8'h81, 8'h00, 8'h81, 8'hA5},
    {3'd0, 2'd2, 8'h00, 8'h00, 8'h81, 8'hA5}
  };
  string vtag [NV] = '{"R2 R3", "R3 R8", "R4", "R4", "R2", "R9", "R10", "R5", "R5"};

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_idx_i = a;
    #1 d = rd_data_o;
  endtask

  task automatic txn(input logic [2:0] a, input int n, input logic [7:0] d0, input logic [7:0] d1);
    @(negedge clk_i); blk_start_i = 1; blk_idx_i = a;
    @(negedge clk_i); blk_start_i = 0;
    for (int i = 0; i < n; i++) begin
      wr_i = 1; wr_data_i = (i == 0) ? d0 : d1;
      @(negedge clk_i);
    end
    wr_i = 0; blk_end_i = 1;
    @(negedge clk_i); blk_end_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    do_reset();
    rd(3'd0, d);  check("R1 reg0", d, 8'h6D & 8'hFE);
    rd(3'd1, d);  check("R1 reg1", d, 8'hFF);
    check("R1 fs_o", {3'b0, fs_o}, 8'h16);
    check("R1 clk_en_o", clk_en_o, 8'hFF);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] e0, e1;
      e0 = VEC[v][15:8]; e1 = VEC[v][7:0];
      txn(VEC[v][36:34], int'(VEC[v][33:32]), VEC[v][31:24], VEC[v][23:16]);
      rd(3'd0, d); check({vtag[v], " reg0"}, d, e0);
      rd(3'd1, d); check({vtag[v], " reg1"}, d, e1);
      check({vtag[v], " R6 fs_o"}, {3'b0, fs_o}, {3'b0, e0[5:1]});
      check({vtag[v], " R6 spread_o"}, {7'b0, spread_o}, {7'b0, e0[6]});
      check({vtag[v], " R8 clk_en_o"}, clk_en_o, e1);
    end

    // R7: register 0 is stored state, register 4 follows the pins
    fs_strap_i = 5'b00011; spread_i = 1'b0;
    rd(3'd0, d); check("R7 reg0 stored", d, 8'h81);
    check("R7 fs_o unchanged", {3'b0, fs_o}, 8'h00);
    rd(3'd4, d); check("R7 pins", d, 8'h03);
    spread_i = 1'b1;
    rd(3'd4, d); check("R7 pins live", d, 8'h23);
    spread_i = 1'b0;
    rd(3'd5, d); check("R9 read unimpl 5", d, 8'h00);
    rd(3'd7, d); check("R9 read unimpl 7", d, 8'h00);

    // R5: reset clears the lock and reloads straps
    do_reset();
    rd(3'd0, d); check("R5 R1 reg0 after reset", d, 8'h06);
    check("R1 clk_en_o after reset", clk_en_o, 8'hFF);

    // R10: stray write outside a transaction
    txn(3'd0, 1, 8'h07, 8'h00);
    txn(3'd1, 1, 8'hF0, 8'h00);
    rd(3'd1, d); check("R8 reg1 enabled write", d, 8'hF0);
    @(negedge clk_i); blk_idx_i = 3'd1; wr_i = 1; wr_data_i = 8'h00;
    @(negedge clk_i); wr_i = 0;
    @(negedge clk_i);
    rd(3'd1, d); check("R10 stray write ignored", d, 8'hF0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule